// File: doc/BRIEF.md
# Six-Channel Polarity-Selectable Pulse-Width Modulator

This block produces six independent 8-bit edge-aligned pulse trains. Each channel has a counter that advances only on that channel's own tick strobe. The counter runs from zero up to the programmed period minus one and then returns to zero, which starts a new period. The channel output is compared against a duty value. A per-channel polarity bit picks the level the output has at the start of every period. The output switches to the other level once the counter reaches the duty value.

Software programs the block through a synchronous write port and a combinational read port. Period and duty are banked per channel and reached through a channel-select register. Setting a channel's enable bit does not start its waveform at once. The channel waits for the first tick of its own source, and that tick opens its first period. A control flag that joins channels 0 and 1 blocks channel 0: its enable bit is then ignored and its output line stays low.

Top module: `pwm6_top`

## Requirements
- R1: Register map by address: 0 enable (bit n = channel n), 1 polarity (bit n = channel n), 2 channel select (bits 2:0), 3 period of the selected channel, 4 duty of the selected channel, 5 control (bit 0 = join flag for channels 0 and 1). Bits 7:6 of enable and polarity, and bits 7:1 of control, read as zero. Period and duty read as zero when the select value is 6 or 7.
- R2: After reset every register reads zero and all six outputs are low.
- R3: With polarity 1 and the channel running, the output is high while counter < duty and low otherwise.
- R4: With polarity 0 and the channel running, the output is low while counter < duty and high otherwise.
- R5: After the enable bit is set, the output stays low until the channel's first tick. That tick sets the counter to 0 and starts a period. From the next clock cycle on, the output shows the level for counter 0.
- R6: A running channel's counter goes to (counter+1) mod period on each of its ticks. A period of 0 behaves like a period of 1.
- R7: Clearing a channel's enable bit drives its output low from the next clock cycle and returns its counter to 0.
- R8: While the join flag is 1, output 0 stays low whatever the value of enable bit 0. After the flag is cleared with channel 0 enabled, output 0 stays low until channel 0's next tick.
- R9: Duty 0 holds the output at the post-duty level for the whole period. Duty >= period holds it at the starting level for the whole period.
- R10: A polarity write takes effect in the next clock cycle without waiting for a period boundary.
- R11: A tick or an enable on one channel never changes another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data (combinational) |
| src_tick | input | 6 | Per-channel clock-source tick strobe |
| pwm_out | output | 6 | Per-channel pulse output |

## Verification
A wrong counter value moves the duty edge or the wrap point. This shows on the output within one period of the affected channel, and in the same clock cycle if the counter is compared against the duty. A start flag left set or cleared when it should not be shows as output activity before the first aligning tick, or as a silent output after it, in the cycle after that tick. A wrong polarity or join flag is visible in the cycle after the register write. The bench sweeps every duty from 0 to period+1, for several periods, both polarities and all six channels, and predicts each output from modular arithmetic.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE  = 3'd0,
    A_POLAR   = 3'd1,
    A_SELECT  = 3'd2,
    A_PERIOD  = 3'd3,
    A_DUTY    = 3'd4,
    A_CONTROL = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/pwm6_regs.sv
module pwm6_regs
  import pwm6_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 8,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [CNT_W-1:0]              rd_data,
  output logic [NUM_CH-1:0]             enable_o,
  output logic [NUM_CH-1:0]             polar_o,
  output logic                          join01_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  period_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  duty_o
);
  logic [SEL_W-1:0] sel_q;
  logic             sel_ok;

  assign sel_ok = (32'(sel_q) < NUM_CH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o <= '0;
      polar_o  <= '0;
      join01_o <= 1'b0;
      sel_q    <= '0;
      period_o <= '0;
      duty_o   <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_ENABLE:  enable_o <= wr_data[NUM_CH-1:0];
        A_POLAR:   polar_o  <= wr_data[NUM_CH-1:0];
        A_SELECT:  sel_q    <= wr_data[SEL_W-1:0];
        A_PERIOD:  if (sel_ok) period_o[sel_q] <= wr_data;
        A_DUTY:    if (sel_ok) duty_o[sel_q]   <= wr_data;
        A_CONTROL: join01_o <= wr_data[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      A_ENABLE:  rd_data[NUM_CH-1:0] = enable_o;
      A_POLAR:   rd_data[NUM_CH-1:0] = polar_o;
      A_SELECT:  rd_data[SEL_W-1:0]  = sel_q;
      A_PERIOD:  if (sel_ok) rd_data = period_o[sel_q];
      A_DUTY:    if (sel_ok) rd_data = duty_o[sel_q];
      A_CONTROL: rd_data[0] = join01_o;
      default:   rd_data = '0;
    endcase
  end

  AST_POL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_POLAR) |-> (rd_data[CNT_W-1:NUM_CH] == '0)); // R1
  AST_JOIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CONTROL) |=> (join01_o == $past(wr_data[0]))); // R8
endmodule

// File: rtl/pwm6_channel.sv
module pwm6_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,
  input  logic             tick_i,
  input  logic             polar_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] per);
    if (per == '0 || cnt >= per - 1'b1) return '0;
    return cnt + 1'b1;
  endfunction

  function automatic logic wave_level(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] duty,
                                      input logic pol);
    return pol ? (cnt < duty) : !(cnt < duty);
  endfunction

  logic             running_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_evt;
  logic             step_evt;
  logic             wrap_evt;

  assign start_evt = armed_i && !running_q && tick_i;
  assign step_evt  = armed_i && running_q && tick_i;
  assign wrap_evt  = step_evt && (next_count(cnt_q, period_i) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (!armed_i) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (start_evt) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
    end else if (step_evt) begin
      cnt_q     <= next_count(cnt_q, period_i);
    end
  end

  assign pwm_o = running_q && armed_i && wave_level(cnt_q, duty_i, polar_i);

  AST_WAIT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !tick_i) |=> !running_q); // R5
  AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |=> (cnt_q == '0 && !running_q)); // R7
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && armed_i) |=> (cnt_q == '0)); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_i && running_q && !tick_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/pwm6_top.sv
module pwm6_top
  import pwm6_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [NUM_CH-1:0] src_tick,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]            enable_w;
  logic [NUM_CH-1:0]            polar_w;
  logic                         join01_w;
  logic [NUM_CH-1:0][CNT_W-1:0] period_w;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_w;
  logic [NUM_CH-1:0]            armed_w;

  pwm6_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .enable_o(enable_w), .polar_o(polar_w), .join01_o(join01_w),
    .period_o(period_w), .duty_o(duty_w)
  );

  assign armed_w = enable_w & ~{{(NUM_CH-1){1'b0}}, join01_w};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm6_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .armed_i(armed_w[g]), .tick_i(src_tick[g]),
      .polar_i(polar_w[g]), .period_i(period_w[g]), .duty_i(duty_w[g]),
      .pwm_o(pwm_out[g])
    );
  end

  AST_JOIN_MASKS_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    join01_w |-> !pwm_out[0]); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enable_w[1]) |-> !pwm_out[1]); // R7
endmodule

// File: tb/pwm6_top_bench.sv
module pwm6_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] src_tick = '0;
  logic [5:0] pwm_out;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwm6_top u_pwm6_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_tick(src_tick), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_addr = 3'(a);
    #1 d = int'(rd_data);
  endtask

  task automatic tick(input int mask);
    @(negedge clk);
    src_tick = 6'(mask);
    @(negedge clk);
    src_tick = '0;
  endtask

  function automatic int level(input int cnt, input int duty, input int pol);
    int below = (cnt < duty) ? 1 : 0;
    return (below == pol) ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    int plist[5] = '{1, 2, 3, 5, 8};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v); check("R2 reg", v, 0);
    end
    check("R2 outputs", int'(pwm_out), 0);

    // R1 readback masking
    wr(0, 8'hFF); rd(0, v); check("R1 enable mask", v, 8'h3F);
    wr(0, 0);
    wr(1, 8'hFF); rd(1, v); check("R1 polarity mask", v, 8'h3F);
    wr(1, 0);
    wr(5, 8'hFF); rd(5, v); check("R1 control mask", v, 1);
    wr(5, 0);
    wr(2, 7); rd(2, v); check("R1 select", v, 7);
    wr(3, 8'h55); rd(3, v); check("R1 period out of range", v, 0);
    wr(2, 4); wr(3, 8'hA7); wr(4, 8'h3C);
    rd(3, v); check("R1 period", v, 8'hA7);
    rd(4, v); check("R1 duty", v, 8'h3C);

    // Sweep: channel x period x duty x polarity
    for (int ch = 0; ch < 6; ch++) begin
      for (int pi = 0; pi < 5; pi++) begin
        for (int d = 0; d <= plist[pi] + 1; d++) begin
          for (int pol = 0; pol < 2; pol++) begin
            int p = plist[pi];
            int cnt;
            string tg;
            tg = (d == 0 || d >= p) ? "R9" : (pol == 1 ? "R3 R6" : "R4 R6");
            wr(2, ch); wr(3, p); wr(4, d);
            wr(1, pol << ch); wr(0, 1 << ch);
            check("R5 before tick", int'(pwm_out[ch]), 0);
            tick(6'h3F & ~(1 << ch));
            check("R11 other ticks", int'(pwm_out), 0);
            tick(1 << ch);
            cnt = 0;
            check("R5 first period", int'(pwm_out[ch]), level(cnt, d, pol));
            for (int k = 0; k < 2 * p + 1; k++) begin
              tick(6'h3F);
              cnt = (cnt + 1) % p;
              check(tg, int'(pwm_out[ch]), level(cnt, d, pol));
              check("R11 others low", int'(pwm_out) & ~(1 << ch), 0);
            end
            wr(0, 0);
            check("R7 disable", int'(pwm_out), 0);
          end
        end
      end
    end

    // R6 period 0 behaves as period 1
    wr(2, 3); wr(3, 0); wr(4, 1); wr(1, 8); wr(0, 8);
    tick(8);
    for (int k = 0; k < 3; k++) begin
      tick(8); check("R6 period zero", int'(pwm_out[3]), 1);
    end
    wr(0, 0);

    // R7 counter restarts after re-enable
    wr(2, 4); wr(3, 6); wr(4, 2); wr(1, 16); wr(0, 16);
    tick(16); tick(16); tick(16);
    check("R7 mid period", int'(pwm_out[4]), 0);
    wr(0, 0); wr(0, 16);
    check("R7 waits again", int'(pwm_out[4]), 0);
    tick(16);
    check("R7 counter reset", int'(pwm_out[4]), 1);
    wr(0, 0);

    // R10 polarity change mid-period
    wr(2, 2); wr(3, 8); wr(4, 3); wr(1, 4); wr(0, 4);
    tick(4); tick(4);
    check("R10 before flip", int'(pwm_out[2]), 1);
    wr(1, 0);
    check("R10 after flip", int'(pwm_out[2]), 0);
    tick(4); tick(4);
    check("R10 post duty", int'(pwm_out[2]), 1);
    wr(0, 0);

    // R8 join flag masks channel 0
    wr(5, 1); wr(2, 0); wr(3, 4); wr(4, 2); wr(1, 1); wr(0, 1);
    for (int k = 0; k < 4; k++) begin
      tick(1); check("R8 masked", int'(pwm_out[0]), 0);
    end
    wr(5, 0);
    check("R8 waits tick", int'(pwm_out[0]), 0);
    tick(1);
    check("R8 released", int'(pwm_out[0]), 1);
    wr(0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule